// File: doc/BRIEF.md
# Word-Wide CRC-32 Register Accelerator

This block computes a running CRC-32 checksum over a stream of 32-bit words. Software places each word in a data register. The engine folds that word into an accumulator one byte per clock, starting with the most significant byte. Reading the same register returns the checksum of every word written since the last reload. Reading does not disturb the accumulator, so software can sample an intermediate checksum and then keep feeding words.

The block sits on a simple synchronous register bus. A request is held until `bus_ready` is high at a rising clock edge, and the transfer completes at that edge. A control register holds a reload bit. Writing a one to it returns the accumulator to its seed, and the bit clears itself once the reload is done. A spare byte register gives software a little scratch storage. The spare byte has no link to the checksum logic.

Top module: `crc_word_unit`

## Requirements
- R1: After synchronous reset, the data register (offset 0x0) reads 0xFFFFFFFF, the spare register (offset 0x4) reads 0, the control register (offset 0x8) reads 0, and the idle bus sees `bus_ready` high.
- R2: The checksum uses the fixed generator 0x04C11DB7 and the seed 0xFFFFFFFF. Word bits are taken most significant first. There is no bit reflection and no final inversion. After a reset, the single word 0xABCD1234 gives 0xF7018A40.
- R3: Once a data write is accepted, the engine stays busy for exactly four clock cycles. A data access issued in the next cycle sees `bus_ready` low for exactly four cycles.
- R4: Each accepted data write continues from the current accumulator value. Reading the data register leaves the accumulator unchanged.
- R5: Writing 1 to control bit 0 reloads the accumulator with 0xFFFFFFFF on the following edge. Bit 0 reads 1 in the cycle right after the write and 0 afterwards. Writing control with bit 0 at 0 has no effect.
- R6: While the engine is busy or a reload is pending, data reads, data writes and control writes are stalled with `bus_ready` low. A data read therefore never returns a partial checksum. Control reads are never stalled.
- R7: The spare register stores `bus_wdata[7:0]` and reads with bits 31:8 at zero. It never stalls, even while the engine is busy, and it never changes the checksum.
- R8: Address bits 3:2 pick the register: 0 selects data, 1 selects spare, 2 selects control and 3 selects nothing. Address bits 1:0 are ignored. Offset 0xC reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Transfer request, held until accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_req` and `bus_ready` are high |
| bus_ready | output | 1 | Transfer completes at the edge where this is high |

## Verification
The bound checker watches the following on every cycle:
- the four-cycle length of each busy window;
- the stall of data accesses while the engine is busy;
- the spare register never stalling;
- the one-cycle life of the reload bit and the seed value loaded by it;
- the accumulator holding its value whenever no word is being processed.

Other properties can only be shown by the bench's scenarios, which compare register reads against a bit-serial reference model:
- the numeric checksum of each word sequence;
- the continuation after intermediate reads;
- the masking of the spare byte;
- the ignored offset and the ignored low address bits.

// File: rtl/crc_word_pkg.sv
`timescale 1ns/1ps
package crc_word_pkg;

    localparam int CRC_W  = 32;
    localparam int LANE_W = 8;
    localparam int ADDR_W = 4;
    localparam int SPARE_W = 8;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        RSEL_DATA  = 2'd0,
        RSEL_SPARE = 2'd1,
        RSEL_CTRL  = 2'd2,
        RSEL_NONE  = 2'd3
    } rsel_e;

    typedef struct packed {
        rsel_e sel;
        logic  rd;
        logic  wr;
    } bus_op_t;

    // One bit of the shift-register division, MSB first.
    function automatic logic [CRC_W-1:0] crc_bit_step(
        input logic [CRC_W-1:0] c,
        input logic             b,
        input logic [CRC_W-1:0] poly
    );
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/crc_addr_decode.sv
`timescale 1ns/1ps
module crc_addr_decode
    import crc_word_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    output bus_op_t       op
);
    logic upper_hit;

    generate
        if (AW > 4) begin : g_wide
            assign upper_hit = (bus_addr[AW-1:4] != '0);
        end else begin : g_narrow
            assign upper_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        op.rd = bus_req & ~bus_we;
        op.wr = bus_req & bus_we;
        if (upper_hit) op.sel = RSEL_NONE;
        else           op.sel = rsel_e'(bus_addr[3:2]);
    end
endmodule

// File: rtl/crc_lane_engine.sv
`timescale 1ns/1ps
module crc_lane_engine
    import crc_word_pkg::*;
#(
    parameter int                CW     = CRC_W,
    parameter int                LW     = LANE_W,
    parameter logic [CRC_W-1:0]  POLY   = CRC_POLY,
    parameter logic [CRC_W-1:0]  SEED   = CRC_SEED
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reinit,
    input  logic          load,
    input  logic [CW-1:0] load_word,
    output logic          busy,
    output logic [CW-1:0] crc
);
    localparam int STEPS = CW / LW;
    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [CW-1:0]    crc_q, word_q, lane_next;
    logic [CNT_W-1:0] step_q;
    logic             busy_q;

    always_comb begin
        lane_next = crc_q;
        for (int i = 0; i < LW; i++) begin
            lane_next = crc_bit_step(lane_next, word_q[CW-1-i], POLY);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q  <= SEED;
            word_q <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
        end else if (reinit) begin
            crc_q  <= SEED;
            busy_q <= 1'b0;
            step_q <= '0;
        end else if (busy_q) begin
            crc_q  <= lane_next;
            word_q <= word_q << LW;
            if (step_q == CNT_W'(STEPS - 1)) begin
                busy_q <= 1'b0;
                step_q <= '0;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end else if (load) begin
            word_q <= load_word;
            busy_q <= 1'b1;
            step_q <= '0;
        end
    end

    assign busy = busy_q;
    assign crc  = crc_q;
endmodule

// File: rtl/crc_side_regs.sv
`timescale 1ns/1ps
module crc_side_regs
    import crc_word_pkg::*;
#(
    parameter int SW = SPARE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          spare_wr,
    input  logic          ctrl_wr,
    input  logic [SW-1:0] wdata,
    output logic [SW-1:0] spare_q,
    output logic          reload_pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            spare_q     <= '0;
            reload_pend <= 1'b0;
        end else begin
            if (spare_wr) spare_q <= wdata;
            reload_pend <= ctrl_wr & wdata[0];
        end
    end
endmodule

// File: rtl/crc_word_unit.sv
`timescale 1ns/1ps
module crc_word_unit
    import crc_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CRC_W-1:0]  bus_wdata,
    output logic [CRC_W-1:0]  bus_rdata,
    output logic              bus_ready
);
    bus_op_t             op;
    logic                eng_busy, reload_pend, eng_hold, stall;
    logic                data_wr, spare_wr, ctrl_wr;
    logic [CRC_W-1:0]    crc_q;
    logic [SPARE_W-1:0]  spare_q;

    crc_addr_decode #(.AW(ADDR_W)) u_dec (
        .bus_req (bus_req),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .op      (op)
    );

    assign eng_hold = eng_busy | reload_pend;
    assign stall    = eng_hold & (((op.sel == RSEL_DATA) & (op.rd | op.wr)) |
                                  ((op.sel == RSEL_CTRL) & op.wr));
    assign bus_ready = ~stall;

    assign data_wr  = op.wr & (op.sel == RSEL_DATA) & ~stall;
    assign spare_wr = op.wr & (op.sel == RSEL_SPARE);
    assign ctrl_wr  = op.wr & (op.sel == RSEL_CTRL) & ~stall;

    crc_lane_engine #(
        .CW(CRC_W), .LW(LANE_W), .POLY(CRC_POLY), .SEED(CRC_SEED)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .reinit   (reload_pend),
        .load     (data_wr),
        .load_word(bus_wdata),
        .busy     (eng_busy),
        .crc      (crc_q)
    );

    crc_side_regs #(.SW(SPARE_W)) u_side (
        .clk        (clk),
        .rst        (rst),
        .spare_wr   (spare_wr),
        .ctrl_wr    (ctrl_wr),
        .wdata      (bus_wdata[SPARE_W-1:0]),
        .spare_q    (spare_q),
        .reload_pend(reload_pend)
    );

    always_comb begin
        unique case (op.sel)
            RSEL_DATA:  bus_rdata = crc_q;
            RSEL_SPARE: bus_rdata = {{(CRC_W-SPARE_W){1'b0}}, spare_q};
            RSEL_CTRL:  bus_rdata = {{(CRC_W-1){1'b0}}, reload_pend};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/crc_word_unit_chk.sv
`timescale 1ns/1ps
module crc_word_unit_chk
    import crc_word_pkg::*;
#(
    parameter int STEPS = CRC_W / LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              eng_busy,
    input logic              reload_pend,
    input logic              data_wr,
    input logic [CRC_W-1:0]  crc_q
);
    localparam int BW = $clog2(STEPS + 1);
    logic [BW-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst)           bcnt <= '0;
        else if (eng_busy) bcnt <= bcnt + 1'b1;
        else               bcnt <= '0;
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
        eng_busy |-> (bcnt < BW'(STEPS))); // R3
    AST_BUSY_FULL: assert property (@(posedge clk) disable iff (rst)
        $fell(eng_busy) |-> (bcnt == BW'(STEPS))); // R3
    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> eng_busy); // R3
    AST_DATA_STALL: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_addr[3:2] == 2'd0 && eng_busy) |-> !bus_ready); // R6
    AST_SPARE_READY: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_addr[3:2] == 2'd1) |-> bus_ready); // R7
    AST_RELOAD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        reload_pend |=> !reload_pend); // R5
    AST_RELOAD_SEED: assert property (@(posedge clk) disable iff (rst)
        reload_pend |=> (crc_q == CRC_SEED)); // R5
    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!eng_busy && !reload_pend && !data_wr) |=> $stable(crc_q)); // R4
endmodule

bind crc_word_unit crc_word_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .bus_ready  (bus_ready),
    .eng_busy   (eng_busy),
    .reload_pend(reload_pend),
    .data_wr    (data_wr),
    .crc_q      (crc_q)
);

// File: tb/tb_crc_word_unit.sv
`timescale 1ns/1ps
module tb_crc_word_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] POLY = 32'h04C1_1DB7;
    localparam logic [31:0] SEED = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_word_unit dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 32; i++) begin
            if (r[31] ^ w[31-i]) r = {r[30:0], 1'b0} ^ POLY;
            else                 r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [3:0] a, input logic we, input logic [31:0] d,
                        output logic [31:0] rd, output int stalls);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        stalls = 0;
        #1;
        while (!bus_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        rd = bus_rdata;
        @(posedge clk);
        #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int stalls);
        logic [31:0] dummy;
        xfer(a, 1'b1, d, dummy, stalls);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v, output int stalls);
        xfer(a, 1'b0, 32'h0, v, stalls);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, m;
        logic [7:0]  sp;
        int s;
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1 check("R1 idle ready", {31'd0, bus_ready}, 32'd1);
        rd(4'h0, v, s); check("R1 data seed", v, SEED);
        rd(4'h4, v, s); check("R1 spare zero", v, 32'd0);
        rd(4'h8, v, s); check("R1 ctrl zero", v, 32'd0);

        // R2 known vector, R3 stall length
        wr(4'h0, 32'hABCD_1234, s);
        rd(4'h0, v, s);
        check("R3 stall cycles", s, 32'd4);
        check("R2 known vector", v, 32'hF701_8A40);
        check("R2 model agrees", crc_ref(SEED, 32'hABCD_1234), 32'hF701_8A40);

        // R4 continuation after a read
        m = crc_ref(32'hF701_8A40, 32'h1234_5678);
        wr(4'h0, 32'h1234_5678, s);
        rd(4'h0, v, s); check("R4 continue", v, m);
        rd(4'h0, v, s); check("R4 read keeps value", v, m);

        // R5 reload bit, self-clearing
        wr(4'h8, 32'h0000_0000, s);
        rd(4'h0, v, s); check("R5 zero write no effect", v, m);
        wr(4'h8, 32'h0000_0001, s);
        rd(4'h8, v, s); check("R5 bit set then", v, 32'd1);
        rd(4'h8, v, s); check("R5 bit cleared", v, 32'd0);
        rd(4'h0, v, s); check("R5 seed reloaded", v, SEED);

        // R6 back-to-back writes stall, control read during busy does not
        wr(4'h0, 32'h0000_0000, s);
        rd(4'h8, v, s);
        check("R6 ctrl read no stall", s, 32'd0);
        check("R6 ctrl read value", v, 32'd0);
        wr(4'h0, 32'hFFFF_FFFF, s);
        check("R6 write stalled", (s > 0) ? 32'd1 : 32'd0, 32'd1);
        m = crc_ref(crc_ref(SEED, 32'h0), 32'hFFFF_FFFF);
        rd(4'h0, v, s); check("R6 no partial result", v, m);

        // R7 spare byte
        wr(4'h0, 32'hDEAD_BEEF, s);
        wr(4'h4, 32'hFFFF_A5C3, s);
        check("R7 spare no stall", s, 32'd0);
        rd(4'h4, v, s); check("R7 spare masked", v, 32'h0000_00C3);
        m = crc_ref(m, 32'hDEAD_BEEF);
        rd(4'h0, v, s); check("R7 crc untouched", v, m);

        // R8 decode
        wr(4'hC, 32'h0000_0001, s);
        rd(4'hC, v, s); check("R8 hole reads zero", v, 32'd0);
        rd(4'h0, v, s); check("R8 hole write ignored", v, m);
        rd(4'h3, v, s); check("R8 low bits ignored", v, m);
        rd(4'h5, v, s); check("R8 spare alias", v, 32'h0000_00C3);

        // random mix
        sp = 8'hC3;
        for (int n = 0; n < 80; n++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 6);
            d = $urandom;
            case (op)
                0, 1: begin wr(4'h0, d, s); m = crc_ref(m, d); end
                2: begin rd(4'h0, v, s); check("R4 random data", v, m); end
                3: begin wr(4'h4, d, s); sp = d[7:0]; end
                4: begin rd(4'h4, v, s); check("R7 random spare", v, {24'd0, sp}); end
                default: begin
                    if (d[1:0] == 2'b00) begin
                        wr(4'h8, 32'h1, s); m = SEED;
                        rd(4'h8, v, s); check("R5 random set", v, 32'd1);
                    end else begin
                        rd(4'h8, v, s); check("R5 random clear", v, 32'd0);
                    end
                end
            endcase
        end
        rd(4'h0, v, s); check("R2 random final", v, m);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule